// File: doc/BRIEF.md
# USB Token Packet Builder

This block assembles host-side USB token packets. A command selects one of four token kinds (SETUP, IN, OUT or start-of-frame). It also supplies either a 7-bit device address with a 4-bit endpoint number, or an 11-bit frame number for start-of-frame. The block turns the command into the three bytes that follow the sync pattern on the wire: the PID byte with its check nibble, then the 11-bit token field, then the 5-bit CRC. A downstream bit-level transmitter emits sync, applies line coding and bit stuffing, and takes the bytes one at a time.

The CRC is computed one bit per clock over the 11-bit field, least significant bit first. It starts at the moment the command is accepted, so it runs while the first two bytes are being handed off. The byte output is a valid/ready stream. `out_valid` and the presented byte stay unchanged until a cycle in which `out_ready` is also high. `out_ready` may be held low for any number of cycles, and the block simply waits. The third byte is offered only once the CRC is complete. Commands use a plain valid/ready pair that is ready only while the block is idle.

Top module: `usb_token_builder`

## Requirements
- R1: After reset, `cmd_ready` is 1, `out_valid` is 0 and `done` is 0.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 from the cycle after acceptance until packet completion. Commands offered while busy are ignored and do not alter the bytes being sent.
- R3: The first byte is the PID byte. Bits 3:0 hold the PID code and bits 7:4 hold its one's complement. `cmd_kind` 0 = OUT (code 0001), 1 = IN (1001), 2 = SOF (0101), 3 = SETUP (1101). The resulting bytes are 0xE1, 0x69, 0xA5 and 0x2D.
- R4: For OUT, IN and SETUP, the 11-bit field is the address in bits 6:0 and the endpoint in bits 10:7. The second byte is field bits 7:0 and bits 2:0 of the third byte are field bits 10:8.
- R5: For SOF, the field is `cmd_frame`, and `cmd_addr` and `cmd_endp` have no effect on any byte.
- R6: The CRC uses polynomial x^5+x^2+1, is preset to 11111, and takes the field least significant bit first. It is sent inverted in bits 7:3 of the third byte, with bit 3 carrying the inverted CRC MSB. For example, address 0 with endpoint 0 yields a third byte of 0x10.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values on the next cycle.
- R8: Each command yields exactly three handshaken bytes. `out_last` is 1 only on the third byte, and only together with `out_valid`.
- R9: `done` is 1 for exactly one cycle, the cycle after the third byte's handshake. In that same cycle `cmd_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command will be taken |
| cmd_kind | input | 2 | Token kind: 0 OUT, 1 IN, 2 SOF, 3 SETUP |
| cmd_addr | input | 7 | Device address (long tokens) |
| cmd_endp | input | 4 | Endpoint number (long tokens) |
| cmd_frame | input | 11 | Frame number (SOF) |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Transmitter takes the byte |
| out_data | output | 8 | Byte, sent LSB first downstream |
| out_last | output | 1 | Final byte of the packet |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `out_ready` is the only input that affects the byte stream while a packet is in flight, and that reset is held long enough for at least one clock edge. The stimulus changes inputs only on falling edges. It holds `out_ready` low for irregular stretches, including before the CRC is ready. While the block is busy it drives bogus commands, and it samples every result half a cycle away from the active edge.

// File: rtl/usb_tok_pkg.sv
package usb_tok_pkg;
  localparam int ADDR_W  = 7;
  localparam int ENDP_W  = 4;
  localparam int FIELD_W = ADDR_W + ENDP_W;
  localparam int CRC_W   = 5;
  localparam int NBYTES  = 3;

  typedef enum logic [1:0] {
    TK_OUT   = 2'd0,
    TK_IN    = 2'd1,
    TK_SOF   = 2'd2,
    TK_SETUP = 2'd3
  } tok_kind_e;

  function automatic logic [3:0] pid_code(tok_kind_e k);
    case (k)
      TK_OUT:   return 4'b0001;
      TK_IN:    return 4'b1001;
      TK_SOF:   return 4'b0101;
      default:  return 4'b1101;
    endcase
  endfunction
endpackage

// File: rtl/tok_field_former.sv
module tok_field_former
  import usb_tok_pkg::*;
(
  input  logic [1:0]         kind,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [ENDP_W-1:0]  endp,
  input  logic [FIELD_W-1:0] frame,
  output logic [7:0]         pid_byte,
  output logic [FIELD_W-1:0] field
);
  tok_kind_e k;
  logic [3:0] code;

  always_comb begin
    k        = tok_kind_e'(kind);
    code     = pid_code(k);
    pid_byte = {~code, code};
    if (k == TK_SOF) field = frame;
    else             field = {endp, addr};
  end
endmodule

// File: rtl/tok_crc_serial.sv
module tok_crc_serial #(
  parameter int          W    = 11,
  parameter int          CW   = 5,
  parameter logic [CW-1:0] POLY = 5'b00101,
  parameter logic [CW-1:0] INIT = 5'b11111
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  field,
  output logic [CW-1:0] crc,
  output logic          crc_ok
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     shreg;
  logic [CNT_W-1:0] left;
  logic             armed;
  logic [CW-1:0]    crc_nx;
  logic             fb;

  always_comb begin
    fb = crc[CW-1] ^ shreg[0];
    for (int i = 0; i < CW; i++) begin
      if (i == 0) crc_nx[i] = fb & POLY[0];
      else        crc_nx[i] = crc[i-1] ^ (fb & POLY[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
      armed <= 1'b0;
      crc   <= INIT;
    end else if (start) begin
      shreg <= field;
      left  <= CNT_W'(W);
      armed <= 1'b1;
      crc   <= INIT;
    end else if (left != '0) begin
      shreg <= shreg >> 1;
      left  <= left - 1'b1;
      crc   <= crc_nx;
    end
  end

  assign crc_ok = armed && (left == '0);
endmodule

// File: rtl/tok_byte_seq.sv
module tok_byte_seq
  import usb_tok_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [7:0]         pid_in,
  input  logic [FIELD_W-1:0] field_in,
  output logic               start,
  input  logic [CRC_W-1:0]   crc,
  input  logic               crc_ok,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_data,
  output logic               out_last,
  output logic               done
);
  localparam int IDX_W = $clog2(NBYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

  typedef enum logic {S_IDLE, S_SEND} seq_st_e;

  seq_st_e            st;
  logic [IDX_W-1:0]   idx;
  logic [7:0]         pid_q;
  logic [FIELD_W-1:0] field_q;
  logic [CRC_W-1:0]   crc_tx;
  logic [7:0]         bytes [NBYTES];
  logic               fire;

  generate
    for (genvar g = 0; g < CRC_W; g++) begin : g_crc_rev
      assign crc_tx[g] = ~crc[CRC_W-1-g];
    end
  endgenerate

  always_comb begin
    bytes[0] = pid_q;
    bytes[1] = field_q[7:0];
    bytes[2] = {crc_tx, field_q[FIELD_W-1:8]};
  end

  assign cmd_ready = (st == S_IDLE);
  assign start     = cmd_valid && cmd_ready;
  assign out_valid = (st == S_SEND) && ((idx != LAST_IDX) || crc_ok);
  assign out_data  = (st == S_SEND) ? bytes[idx] : 8'h00;
  assign out_last  = out_valid && (idx == LAST_IDX);
  assign fire      = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      pid_q   <= '0;
      field_q <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st      <= S_SEND;
          idx     <= '0;
          pid_q   <= pid_in;
          field_q <= field_in;
        end
        default: if (fire) begin
          if (idx == LAST_IDX) begin
            st   <= S_IDLE;
            idx  <= '0;
            done <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/usb_token_builder.sv
module usb_token_builder
  import usb_tok_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [1:0]   cmd_kind,
  input  logic [6:0]   cmd_addr,
  input  logic [3:0]   cmd_endp,
  input  logic [10:0]  cmd_frame,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [7:0]   out_data,
  output logic         out_last,
  output logic         done
);
  logic [7:0]         pid_c;
  logic [FIELD_W-1:0] field_c;
  logic               start;
  logic [CRC_W-1:0]   crc;
  logic               crc_ok;

  tok_field_former u_former (
    .kind(cmd_kind), .addr(cmd_addr), .endp(cmd_endp), .frame(cmd_frame),
    .pid_byte(pid_c), .field(field_c)
  );

  tok_crc_serial #(.W(FIELD_W), .CW(CRC_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .start(start), .field(field_c),
    .crc(crc), .crc_ok(crc_ok)
  );

  tok_byte_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .pid_in(pid_c), .field_in(field_c), .start(start),
    .crc(crc), .crc_ok(crc_ok),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .done(done)
  );
endmodule

// File: rtl/usb_token_builder_chk.sv
module usb_token_builder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       done
);
  assert_hold_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  assert_hold_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data) && $stable(out_last));

  assert_last_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_busy_no_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !cmd_ready);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready && out_last) && cmd_ready);
endmodule

bind usb_token_builder usb_token_builder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last), .done(done)
);

// File: tb/usb_token_builder_test.sv
module usb_token_builder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_kind = '0;
  logic [6:0]  cmd_addr = '0;
  logic [3:0]  cmd_endp = '0;
  logic [10:0] cmd_frame = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_last;
  logic        done;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  usb_token_builder uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_pid(input logic [1:0] k);
    logic [3:0] c;
    case (k)
      2'd0: c = 4'b0001;
      2'd1: c = 4'b1001;
      2'd2: c = 4'b0101;
      default: c = 4'b1101;
    endcase
    return {~c, c};
  endfunction

  function automatic logic [4:0] ref_crc(input logic [10:0] f);
    logic [4:0] r = 5'b11111;
    for (int i = 0; i < 11; i++) begin
      logic b = r[4] ^ f[i];
      r = {r[3:0], 1'b0} ^ (b ? 5'b00101 : 5'b00000);
    end
    return r;
  endfunction

  // Runs one packet; ready_pat bit i gives out_ready in cycle i.
  task automatic run_token(input string name, input logic [1:0] k,
                           input logic [6:0] a, input logic [3:0] e,
                           input logic [10:0] fr, input logic [31:0] ready_pat,
                           input bit noise, input logic [7:0] exp2_known,
                           input bit use_known);
    logic [10:0] f;
    logic [4:0]  c;
    logic [7:0]  exp [3];
    logic [7:0]  held;
    bit          was_stalled;
    int          got;
    int          cyc;
    f = (k == 2'd2) ? fr : {e, a};
    c = ref_crc(f);
    exp[0] = ref_pid(k);
    exp[1] = f[7:0];
    exp[2] = {~c[0], ~c[1], ~c[2], ~c[3], ~c[4], f[10:8]};
    if (use_known) chk(exp[2] == exp2_known, "R6 model", exp[2], exp2_known);

    @(negedge clk);
    chk(cmd_ready == 1'b1, "R2 ready when idle", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_kind = k; cmd_addr = a; cmd_endp = e; cmd_frame = fr;
    @(negedge clk);
    chk(cmd_ready == 1'b0, "R2 busy after accept", cmd_ready, 0);
    if (noise) begin
      cmd_kind = ~k; cmd_addr = ~a; cmd_endp = ~e; cmd_frame = ~fr;
    end else begin
      cmd_valid = 1'b0;
    end
    got = 0; cyc = 0; was_stalled = 1'b0; held = '0;
    while (got < 3 && cyc < 200) begin
      out_ready = ready_pat[cyc % 32];
      if (cyc == 3) cmd_valid = 1'b0;
      if (was_stalled) begin
        chk(out_valid == 1'b1, {"R7 valid held ", name}, out_valid, 1);
        chk(out_data == held, {"R7 data held ", name}, out_data, held);
      end
      if (out_valid) begin
        chk(out_last == (got == 2), {"R8 last flag ", name}, out_last, got == 2);
        if (out_ready) begin
          chk(out_data == exp[got], {"R3/R4/R5/R6 byte ", name}, out_data, exp[got]);
          got++;
          was_stalled = 1'b0;
        end else begin
          was_stalled = 1'b1;
          held = out_data;
        end
      end else begin
        chk(out_last == 1'b0, {"R8 last without valid ", name}, out_last, 0);
        was_stalled = 1'b0;
      end
      chk(done == 1'b0, {"R9 no early done ", name}, done, 0);
      @(negedge clk);
      cyc++;
    end
    chk(got == 3, {"R8 three bytes ", name}, got, 3);
    out_ready = 1'b0;
    chk(done == 1'b1, {"R9 done pulse ", name}, done, 1);
    chk(cmd_ready == 1'b1, {"R9 ready with done ", name}, cmd_ready, 1);
    @(negedge clk);
    chk(done == 1'b0, {"R9 done one cycle ", name}, done, 0);
    chk(out_valid == 1'b0, {"R8 no fourth byte ", name}, out_valid, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_sof_ignores_addr();
    // R5: two SOF packets with same frame, different addr/endp
    run_token("sof_a", 2'd2, 7'h00, 4'h0, 11'h2A5, 32'hFFFF_FFFF, 1'b0, 8'h00, 1'b0);
    run_token("sof_b", 2'd2, 7'h7F, 4'hF, 11'h2A5, 32'h5555_5555, 1'b0, 8'h00, 1'b0);
  endtask

  initial begin
    #3_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    // R6 known vector: SETUP addr 0 ep 0 -> 2D 00 10
    run_token("setup0", 2'd3, 7'h00, 4'h0, 11'h000, 32'hFFFF_FFFF, 1'b0, 8'h10, 1'b1);
    // R3/R4 long tokens, varied back-pressure
    run_token("in",    2'd1, 7'h15, 4'h1, 11'h000, 32'h0000_F0F1, 1'b0, 8'h00, 1'b0);
    run_token("out",   2'd0, 7'h3A, 4'hA, 11'h000, 32'hAAAA_AAAB, 1'b0, 8'h00, 1'b0);
    run_token("setup", 2'd3, 7'h7F, 4'hF, 11'h000, 32'h0003_0007, 1'b0, 8'h00, 1'b0);
    // R2 busy commands ignored
    run_token("noise", 2'd1, 7'h42, 4'h5, 11'h123, 32'hFFFF_FFF0, 1'b1, 8'h00, 1'b0);
    // R5 SOF with frame at extremes
    t_sof_ignores_addr();
    run_token("sofmax", 2'd2, 7'h11, 4'h3, 11'h7FF, 32'hFFFF_FFFF, 1'b0, 8'h00, 1'b0);
    run_token("sof0",   2'd2, 7'h6C, 4'h9, 11'h000, 32'h0F0F_0F0F, 1'b0, 8'h00, 1'b0);
    // back-to-back with a reset in between (R1)
    t_reset();
    run_token("after_rst", 2'd0, 7'h01, 4'h2, 11'h000, 32'hFFFF_FFFF, 1'b0, 8'h00, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule